// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block lets a processor core reach memory outside the chip over an 8-bit bus on which the low address byte and the data byte share the same pins. A second 8-bit port carries the high address byte. An address latch enable output, an active-low program-store strobe, and active-low read and write strobes frame each transfer. The core hands over one request at a time: a code fetch, a code-constant read, a data read or a data write. It gets back a one-clock ready pulse with the returned byte and a flag saying whether the access was served on-chip.

Code requests are routed either to the on-chip ROM or to the external bus. The choice depends on the ROM size parameter and on an external-access strap pin, which is captured only while reset is asserted. An external transfer always spans six CPU clocks. The CPU clock is marked by an enable input, so the same transfer lasts six oscillator clocks in double-speed mode and twelve in standard mode. Pin outputs are registered, so they trail the internal phase by one oscillator clock.

Top module: `xbus_mux_if`

## Requirements
- R1: While reset is asserted, the three strobes are high, ale is low, ad_oe is low and req_ready is low.
- R2: An external transfer returns req_ready exactly six CPU clocks (six cpu_ce edges) after the clock edge on which the request was accepted. That is 6 oscillator clocks with cpu_ce always high and 12 with cpu_ce high every other clock. A request is accepted only on an edge where cpu_ce is high.
- R3: With the latched strap high, a code request whose address is below ROM_BYTES (default 32768, so 0000h–7FFFh) is answered on-chip. req_ready and rsp_onchip rise on the accepting edge and no pin toggles. Code addresses from ROM_BYTES upward go external.
- R4: The strap ext_access_n is captured only while reset is high. With it captured low, every code request goes external, including address 0000h. Changing the pin after reset has no effect on routing.
- R5: Data requests always go external whatever their address. ale is high for exactly the first CPU clock of a data transfer and never during a code transfer.
- R6: req_kind encodes 00 code fetch, 01 code read, 10 data read, 11 data write. psen_n is low for CPU clocks 2–6 of a code transfer. rd_n or wr_n is low for CPU clocks 3–6 of a data read or data write. At most one strobe is low at a time.
- R7: The lower port drives A7:0 with ad_oe high before psen_n falls and when ale falls. It is released (ad_oe low) while psen_n or rd_n is low. It drives the write byte for every clock that wr_n is low. a_hi carries A15:8 whenever ale or a strobe is active.
- R8: For an external code or data read, the byte on ad_in during the last CPU clock of the strobe is returned on rsp_rdata together with req_ready, with rsp_onchip low.
- R9: Only one transfer is outstanding. req_ready is a one-clock pulse, no request is accepted in the ready clock, and changes on the request inputs during a transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | CPU clock enable, one pulse per CPU clock |
| ext_access_n | input | 1 | External-access strap, captured during reset |
| req_valid | input | 1 | Request present, held until req_ready |
| req_kind | input | 2 | Request type (see R6) |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte for a data write |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Returned byte of an external read |
| rsp_onchip | output | 1 | Set with req_ready when the code access was served by on-chip ROM |
| ad_out | output | 8 | Lower port drive value (address low byte or write data) |
| ad_oe | output | 1 | Lower port output enable |
| ad_in | input | 8 | Lower port pin value |
| a_hi | output | 8 | Upper address byte |
| ale | output | 1 | Address latch enable, high active |
| psen_n | output | 1 | Program-store strobe, low active |
| rd_n | output | 1 | Data read strobe, low active |
| wr_n | output | 1 | Data write strobe, low active |

## Verification
Two functions can meet in the same clock. The registered pins still show the last strobe clock of a finished transfer while req_ready is high, and a request held by the core becomes eligible for acceptance right after that. The bench provokes this with back-to-back requests in double-speed mode, including an on-chip fetch directly after an external one. It judges each transfer by counting strobe and ale clocks and by checking lower-port ownership on every clock, including three clocks after ready. A second overlap, request inputs changing while a transfer runs, is provoked by altering address and write data mid-transfer. The bench then confirms that the pins and the written byte keep the original values.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XK_FETCH  = 2'b00,
    XK_CREAD  = 2'b01,
    XK_DREAD  = 2'b10,
    XK_DWRITE = 2'b11
  } xkind_e;

  function automatic logic kind_is_code(xkind_e k);
    return (k == XK_FETCH) || (k == XK_CREAD);
  endfunction
endpackage

// File: rtl/xbus_route.sv
module xbus_route #(
  parameter int ADDR_W    = 16,
  parameter int ROM_BYTES = 32768
) (
  input  logic              code,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ea_lat,
  output logic              go_ext
);
  generate
    if (ROM_BYTES <= 0) begin : g_norom
      logic unused_ok;
      assign unused_ok = code & ea_lat & (|addr);
      assign go_ext    = 1'b1;
    end else begin : g_rom
      localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_BYTES);
      logic above;
      assign above  = ({1'b0, addr} >= ROM_LIM);
      assign go_ext = !code || !ea_lat || above;
    end
  endgenerate
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int CYC_CLKS = 6,
  localparam int PH_W   = $clog2(CYC_CLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_ce,
  input  logic              req_valid,
  input  xkind_e            req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              go_ext,
  input  logic [DATA_W-1:0] ad_in,
  output logic              busy,
  output xkind_e            kind_q,
  output logic [PH_W-1:0]   phase_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_onchip
);
  localparam logic [PH_W-1:0] LAST = PH_W'(CYC_CLKS - 1);

  logic accept;
  assign accept = req_valid && cpu_ce && !busy && !req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      kind_q     <= XK_FETCH;
      phase_q    <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      req_ready  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_onchip <= 1'b0;
    end else begin
      req_ready <= 1'b0;
      if (!busy) begin
        if (accept) begin
          kind_q  <= req_kind;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          phase_q <= '0;
          if (go_ext) begin
            busy <= 1'b1;
          end else begin
            req_ready  <= 1'b1;
            rsp_onchip <= 1'b1;
          end
        end
      end else if (cpu_ce) begin
        if (phase_q == LAST) begin
          busy       <= 1'b0;
          req_ready  <= 1'b1;
          rsp_onchip <= 1'b0;
          if (kind_q != XK_DWRITE) rsp_rdata <= ad_in;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (phase_q <= LAST));
  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);
  assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);
  assert_data_external_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && !kind_is_code(req_kind)) |=> busy);
  assert_onchip_fast_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && !go_ext) |=> (req_ready && rsp_onchip && !busy));
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PH_W         = 3,
  parameter int CODE_ADDR_PH = 1,
  parameter int DATA_ADDR_PH = 2,
  localparam int HI_W        = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  xkind_e            kind_q,
  input  logic [PH_W-1:0]   phase_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  logic              code_k, addr_ph;
  logic              nx_ale, nx_psen, nx_rd, nx_wr, nx_oe;
  logic [DATA_W-1:0] nx_ad;

  always_comb begin
    code_k  = kind_is_code(kind_q);
    addr_ph = code_k ? (phase_q < PH_W'(CODE_ADDR_PH))
                     : (phase_q < PH_W'(DATA_ADDR_PH));
    nx_ale  = busy && !code_k && (phase_q == '0);
    nx_psen = busy && code_k && !addr_ph;
    nx_rd   = busy && (kind_q == XK_DREAD) && !addr_ph;
    nx_wr   = busy && (kind_q == XK_DWRITE) && !addr_ph;
    nx_oe   = busy && (addr_ph || (kind_q == XK_DWRITE));
    nx_ad   = addr_ph ? addr_q[DATA_W-1:0] : wdata_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '0;
      ad_oe  <= 1'b0;
      a_hi   <= '0;
      ale    <= 1'b0;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
    end else begin
      ale    <= nx_ale;
      psen_n <= !nx_psen;
      rd_n   <= !nx_rd;
      wr_n   <= !nx_wr;
      ad_oe  <= nx_oe;
      if (busy) begin
        ad_out <= nx_ad;
        a_hi   <= addr_q[ADDR_W-1:DATA_W];
      end
    end
  end

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  assert_ale_no_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n));
  assert_ale_fall_drive_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> ad_oe);
  assert_read_release_R7: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !ad_oe);
  assert_write_drive_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);
endmodule

// File: rtl/xbus_mux_if.sv
module xbus_mux_if
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ROM_BYTES = 32768,
  parameter int CYC_CLKS  = 6,
  localparam int HI_W     = ADDR_W - DATA_W,
  localparam int PH_W     = $clog2(CYC_CLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_ce,
  input  logic              ext_access_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_onchip,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  logic              ea_lat;
  logic              go_ext;
  logic              busy;
  xkind_e            kind_in, kind_q;
  logic [PH_W-1:0]   phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign kind_in = xkind_e'(req_kind);

  always_ff @(posedge clk) begin
    if (rst) ea_lat <= ext_access_n;
  end

  xbus_route #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) u_route (
    .code   (kind_is_code(kind_in)),
    .addr   (req_addr),
    .ea_lat (ea_lat),
    .go_ext (go_ext)
  );

  xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_CLKS(CYC_CLKS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cpu_ce     (cpu_ce),
    .req_valid  (req_valid),
    .req_kind   (kind_in),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .go_ext     (go_ext),
    .ad_in      (ad_in),
    .busy       (busy),
    .kind_q     (kind_q),
    .phase_q    (phase_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .req_ready  (req_ready),
    .rsp_rdata  (rsp_rdata),
    .rsp_onchip (rsp_onchip)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PH_W(PH_W)) u_pins (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .kind_q  (kind_q),
    .phase_q (phase_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .a_hi    (a_hi),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
  );

  assert_strap_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(ea_lat));
endmodule

// File: tb/tb_xbus_mux_if.sv
module tb_xbus_mux_if;
  localparam int ROM_BYTES = 32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        x2_mode = 1'b1;
  logic [31:0] clk_cnt = 32'd0;
  always @(posedge clk) clk_cnt <= clk_cnt + 32'd1;
  logic cpu_ce;
  assign cpu_ce = x2_mode | clk_cnt[0];

  logic        ext_access_n = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        req_ready, rsp_onchip, ad_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0]  rsp_rdata, ad_out, ad_in, a_hi;

  xbus_mux_if dut (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .ext_access_n(ext_access_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .rsp_onchip(rsp_onchip), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .a_hi(a_hi), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  // external memory model with its own low-address latch
  logic [7:0] lat_lo = 8'h0;
  logic [7:0] xmem    [0:1023];
  logic [7:0] exp_mem [0:1023];

  function automatic logic [7:0] code_byte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  assign ad_in = !psen_n ? code_byte({a_hi, lat_lo}) :
                 (!rd_n  ? xmem[{a_hi[1:0], lat_lo}] : 8'hFF);

  always @(negedge clk) begin
    if (ad_oe && psen_n && rd_n && wr_n) lat_lo <= ad_out;
    if (!wr_n) xmem[{a_hi[1:0], lat_lo}] <= ad_out;
  end

  int nchk = 0;
  int nfail = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  task automatic do_reset(input bit strap);
    @(negedge clk);
    rst = 1'b1; ext_access_n = strap; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", {29'd0, psen_n, rd_n, wr_n}, 32'd7);
    chk("R1", "ale in reset", {31'd0, ale}, 32'd0);
    chk("R1", "ad_oe in reset", {31'd0, ad_oe}, 32'd0);
    chk("R1", "ready in reset", {31'd0, req_ready}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_req(input logic [1:0] k, input logic [15:0] a,
                         input logic [7:0] wd, input bit ea_hi, input bit poke_mid);
    bit code, ext, started, acc, got;
    int mul, n, tail;
    int n_ale, n_psen, n_rd, n_wr, bad_lo, bad_hi;
    logic p_ale, p_psen, p_oe;
    logic [7:0] p_ad, got_rd, exp_rd;
    logic got_onchip;
    logic [9:0] idx;
    code = !k[1];
    ext  = !code || !ea_hi || (a >= 16'(ROM_BYTES));
    mul  = x2_mode ? 1 : 2;
    idx  = a[9:0];
    n = 0; tail = 0; started = 0; got = 0; got_onchip = 0; got_rd = 0;
    n_ale = 0; n_psen = 0; n_rd = 0; n_wr = 0; bad_lo = 0; bad_hi = 0;
    p_ale = 0; p_psen = 1; p_oe = 0; p_ad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    for (int i = 0; i < 80; i++) begin
      acc = cpu_ce && !started && !got;
      @(posedge clk);
      @(negedge clk);
      if (started && !got) n++;
      if (acc) started = 1;
      if (poke_mid && started && !got && n == 2) begin
        req_addr = a ^ 16'hFFFF; req_wdata = ~wd;
      end
      if (ale) n_ale++;
      if (!psen_n) n_psen++;
      if (!rd_n) n_rd++;
      if (!wr_n) n_wr++;
      if (!psen_n && p_psen && !(p_oe && p_ad == a[7:0])) bad_lo++;
      if (p_ale && !ale && !(ad_oe && ad_out == a[7:0])) bad_lo++;
      if ((!psen_n || !rd_n) && ad_oe) bad_lo++;
      if (!wr_n && !(ad_oe && ad_out == wd)) bad_lo++;
      if ((ale || !psen_n || !rd_n || !wr_n) && a_hi != a[15:8]) bad_hi++;
      p_ale = ale; p_psen = psen_n; p_oe = ad_oe; p_ad = ad_out;
      if (!got && req_ready) begin
        got = 1; got_onchip = rsp_onchip; got_rd = rsp_rdata;
        req_valid = 1'b0; req_addr = a; req_wdata = wd; tail = 3;
      end else if (got) begin
        tail--;
        if (tail == 0) break;
      end
    end
    chk("R2", "ready latency in clocks", n, ext ? 6 * mul : 0);
    chk("R3", "on-chip flag", {31'd0, got_onchip}, {31'd0, !ext});
    chk("R5", "ale clocks", n_ale, (ext && !code) ? mul : 0);
    chk("R6", "psen clocks", n_psen, (ext && code) ? 5 * mul : 0);
    chk("R6", "rd clocks", n_rd, (ext && k == 2'b10) ? 4 * mul : 0);
    chk("R6", "wr clocks", n_wr, (ext && k == 2'b11) ? 4 * mul : 0);
    chk("R7", "lower port ownership errors", bad_lo, 0);
    chk("R7", "upper port errors", bad_hi, 0);
    if (ext && k != 2'b11) begin
      exp_rd = code ? code_byte(a) : exp_mem[idx];
      chk("R8", "read data", {24'd0, got_rd}, {24'd0, exp_rd});
    end
    if (ext && k == 2'b11) begin
      exp_mem[idx] = wd;
      chk(poke_mid ? "R9" : "R7", "stored write byte", {24'd0, xmem[idx]}, {24'd0, wd});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [1:0]  rk;
    logic [15:0] ra;
    logic [7:0]  rw;
    void'($urandom(32'd20251));
    for (int i = 0; i < 1024; i++) begin
      xmem[i]    = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    do_reset(1'b1);
    // R3 boundary with strap high, double-speed
    x2_mode = 1'b1;
    run_req(2'b00, 16'h0000, 8'h00, 1, 0);
    run_req(2'b00, 16'h7FFF, 8'h00, 1, 0);
    run_req(2'b00, 16'h8000, 8'h00, 1, 0);
    run_req(2'b01, 16'hC3A5, 8'h00, 1, 0);
    run_req(2'b01, 16'h1234, 8'h00, 1, 0);
    // R5 data goes out even at low addresses
    run_req(2'b10, 16'h0005, 8'h00, 1, 0);
    run_req(2'b11, 16'h0123, 8'hA7, 1, 0);
    run_req(2'b10, 16'h0123, 8'h00, 1, 0);
    // on-chip fetch right after an external cycle
    run_req(2'b00, 16'h0040, 8'h00, 1, 0);
    // R2 standard mode doubles every duration
    x2_mode = 1'b0;
    run_req(2'b00, 16'h8001, 8'h00, 1, 0);
    run_req(2'b10, 16'hF2AB, 8'h00, 1, 0);
    run_req(2'b11, 16'h03FE, 8'h5C, 1, 0);
    run_req(2'b10, 16'h03FE, 8'h00, 1, 0);
    // R9 request inputs changed mid-transfer are ignored
    x2_mode = 1'b1;
    run_req(2'b11, 16'h0234, 8'h3C, 1, 1);
    run_req(2'b10, 16'h0234, 8'h00, 1, 0);
    x2_mode = 1'b0;
    run_req(2'b00, 16'hA0F0, 8'h00, 1, 1);
    // R4 strap low: everything external, later pin change ignored
    do_reset(1'b0);
    x2_mode = 1'b1;
    run_req(2'b00, 16'h0000, 8'h00, 0, 0);
    ext_access_n = 1'b1;
    run_req(2'b00, 16'h0100, 8'h00, 0, 0);
    run_req(2'b01, 16'h7FFF, 8'h00, 0, 0);
    // back to strap high, random traffic
    do_reset(1'b1);
    for (int i = 0; i < 150; i++) begin
      rk = 2'($urandom);
      ra = 16'($urandom);
      rw = 8'($urandom);
      x2_mode = 1'($urandom);
      run_req(rk, ra, rw, 1, 0);
    end
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule